// File: doc/BRIEF.md
# Output Shutdown and Suspend Controller

This block governs power-down and output drive for a clock generator built around several PLLs and a reference oscillator. Two active-low control pins arrive asynchronously: a shutdown/output-enable pin and a suspend pin. Both are synchronized to the reference clock. A low on the shutdown pin always releases every clock output to high impedance. When system shutdown is enabled in configuration, the same low also powers down the oscillator and all PLLs and holds the output divider counters in reset. The suspend pin shares a package pin with a profile-select input, so it acts only when a configuration bit enables it. When it acts, it powers down a chosen set of PLLs (and freezes their logic) and releases a chosen set of outputs to high impedance.

A source map states which PLL, or the reference, feeds each output. An output whose source PLL is suspended must itself be suspended. The block raises an error flag whenever the configuration breaks this rule, and during suspend it still forces such an output to high impedance. After a PLL leaves power-down, outputs fed by it stay at high impedance until that PLL's lock input has been high for a programmable number of consecutive reference cycles. Power-down by shutdown takes priority over suspend.

Top module: `pwr_susp_ctl`

## Requirements
- R1: While rst_n is low, out_en, pll_pd, pll_hold, osc_pd, cnt_rst and cfg_err are all zero.
- R2: A low on oe_shdn_n clears every out_en bit (1 = output driven, 0 = high impedance) on the third rising clock edge after the pin changes. Before that edge out_en is unchanged, and this holds whatever the other configuration is.
- R3: With cfg_sys_shdn_en = 1, a synchronized low on oe_shdn_n drives osc_pd = 1, cnt_rst = 1 and every pll_pd bit to 1. With cfg_sys_shdn_en = 0, those outputs stay 0 during shutdown.
- R4: cfg_out_src holds one SRC_W-bit code per output, with output j at bits [j*SRC_W +: SRC_W]. Code 0 selects the reference, and code k selects PLL k-1. After reset or after PLL p's power-down ends, an output with code p+1 stays disabled until pll_lock[p] has been high for cfg_lock_wait+1 consecutive cycles. A low on pll_lock[p] restarts the count. Outputs fed by the reference need no lock.
- R5: When suspend is active (susp_n low after synchronization and cfg_susp_en = 1), each PLL whose cfg_pll_susp bit is set gets pll_pd = 1 and pll_hold = 1. Each output whose cfg_out_susp bit is set is disabled. Other outputs keep driving.
- R6: With cfg_susp_en = 0, the suspend pin has no effect on any output.
- R7: cfg_err is 1, one cycle after the configuration changes, exactly when some output is fed by a PLL in cfg_pll_susp but is not in cfg_out_susp. During suspend, such an output is disabled anyway.
- R8: While full shutdown is active, pll_hold is all zero and pll_pd is all one, even when suspend is also asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_shdn_n | input | 1 | Asynchronous shutdown / output-enable pin, active low |
| susp_n | input | 1 | Asynchronous suspend pin, active low |
| cfg_sys_shdn_en | input | 1 | Shutdown pin also powers down PLLs, oscillator and counters |
| cfg_susp_en | input | 1 | Suspend function of the shared pin enabled |
| cfg_pll_susp | input | N_PLL | PLLs powered down during suspend |
| cfg_out_susp | input | N_OUT | Outputs released during suspend |
| cfg_out_src | input | N_OUT*SRC_W | Source code per output (0 = reference, k = PLL k-1) |
| cfg_lock_wait | input | LOCK_W | Extra lock-qualification cycles |
| pll_lock | input | N_PLL | Lock indication per PLL |
| out_en | output | N_OUT | Per-output drive enable (0 = high impedance) |
| pll_pd | output | N_PLL | Per-PLL power-down |
| pll_hold | output | N_PLL | Per-PLL logic freeze during suspend |
| osc_pd | output | 1 | Reference oscillator power-down |
| cnt_rst | output | 1 | Output counter reset during full shutdown |
| cfg_err | output | 1 | Suspend configuration breaks the PLL-to-output rule |

## Verification
A stale lock-qualification state shows up as an output that drives too early after a PLL restarts. The bench catches this within cfg_lock_wait+2 cycles of release by checking out_en at the last cycle before enable is due, after a lock glitch has been applied. A wrong synchronizer depth or a missing priority between shutdown and suspend appears on out_en, pll_pd or pll_hold at the exact third edge after a pin change, so latency is checked one cycle early and at the due edge. A dependency the configuration check misses shows as cfg_err staying low one cycle after a broken mask is applied, and as a dependent output still driving during suspend.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    // Source code 0 selects the reference; code k selects PLL k-1.
    localparam int unsigned REF_SRC = 0;

    function automatic logic src_is_pll(input int unsigned code, input int unsigned pll_idx);
        return code == pll_idx + 1;
    endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_LVL}};
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_lock_qual.sv
module pwr_lock_qual #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic              lock,
    input  logic [LOCK_W-1:0] wait_cycles,
    output logic              ready
);

    typedef struct packed {
        logic [LOCK_W-1:0] cnt;
        logic              ready;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pd) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready) begin
            if (!lock) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == wait_cycles) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.ready;

    // R4: qualification completes only on a cycle where lock was seen
    p_ready_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> $past(lock));

    // R4: a power-down always drops qualification
    p_pd_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !st_q.ready);

endmodule

// File: rtl/pwr_cfg_check.sv
module pwr_cfg_check #(
    parameter int N_PLL = 3,
    parameter int N_OUT = 6,
    parameter int SRC_W = 2
) (
    input  logic [N_PLL-1:0]       pll_mask,
    input  logic [N_OUT-1:0]       out_mask,
    input  logic [N_OUT*SRC_W-1:0] out_src,
    output logic [N_OUT-1:0]       dep_mask,
    output logic                   rule_err
);
    import pwr_ctl_pkg::*;

    always_comb begin
        dep_mask = '0;
        for (int j = 0; j < N_OUT; j++) begin
            for (int p = 0; p < N_PLL; p++) begin
                if (pll_mask[p] &&
                    src_is_pll(int'(unsigned'(out_src[j*SRC_W +: SRC_W])), p))
                    dep_mask[j] = 1'b1;
            end
        end
        // Codes beyond N_PLL carry no PLL dependency (treated as reference).
        rule_err = |(dep_mask & ~out_mask);
    end

endmodule

// File: rtl/pwr_susp_ctl.sv
module pwr_susp_ctl #(
    parameter  int N_PLL       = 3,
    parameter  int N_OUT       = 6,
    parameter  int LOCK_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int SRC_W       = $clog2(N_PLL + 1)
) (
    input  logic                   clk_ref,
    input  logic                   rst_n,
    input  logic                   oe_shdn_n,
    input  logic                   susp_n,
    input  logic                   cfg_sys_shdn_en,
    input  logic                   cfg_susp_en,
    input  logic [N_PLL-1:0]       cfg_pll_susp,
    input  logic [N_OUT-1:0]       cfg_out_susp,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input  logic [LOCK_W-1:0]      cfg_lock_wait,
    input  logic [N_PLL-1:0]       pll_lock,
    output logic [N_OUT-1:0]       out_en,
    output logic [N_PLL-1:0]       pll_pd,
    output logic [N_PLL-1:0]       pll_hold,
    output logic                   osc_pd,
    output logic                   cnt_rst,
    output logic                   cfg_err
);
    import pwr_ctl_pkg::*;

    typedef struct packed {
        logic [N_OUT-1:0] out_en;
        logic [N_PLL-1:0] pll_pd;
        logic [N_PLL-1:0] pll_hold;
        logic             osc_pd;
        logic             cnt_rst;
        logic             cfg_err;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             shdn_lvl, susp_lvl;
    logic [N_PLL-1:0] pll_ready;
    logic [N_OUT-1:0] dep_mask;
    logic             rule_err;
    logic [N_OUT-1:0] src_ready;

    pwr_pin_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) shdn_sync_i (
        .clk(clk_ref), .rst_n(rst_n), .pin_async(oe_shdn_n), .pin_sync(shdn_lvl));

    pwr_pin_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) susp_sync_i (
        .clk(clk_ref), .rst_n(rst_n), .pin_async(susp_n), .pin_sync(susp_lvl));

    for (genvar p = 0; p < N_PLL; p++) begin : g_qual
        pwr_lock_qual #(.LOCK_W(LOCK_W)) qual_i (
            .clk(clk_ref), .rst_n(rst_n), .pd(st_q.pll_pd[p]),
            .lock(pll_lock[p]), .wait_cycles(cfg_lock_wait), .ready(pll_ready[p]));
    end

    pwr_cfg_check #(.N_PLL(N_PLL), .N_OUT(N_OUT), .SRC_W(SRC_W)) chk_i (
        .pll_mask(cfg_pll_susp), .out_mask(cfg_out_susp), .out_src(cfg_out_src),
        .dep_mask(dep_mask), .rule_err(rule_err));

    // Per-output source readiness: the reference is always usable.
    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            src_ready[j] = 1'b1;
            for (int p = 0; p < N_PLL; p++) begin
                if (src_is_pll(int'(unsigned'(cfg_out_src[j*SRC_W +: SRC_W])), p))
                    src_ready[j] = pll_ready[p];
            end
        end
    end

    always_comb begin
        logic shdn_act, full_pd, susp_act;
        shdn_act = !shdn_lvl;
        full_pd  = shdn_act && cfg_sys_shdn_en;
        susp_act = !susp_lvl && cfg_susp_en;

        st_d          = st_q;
        st_d.osc_pd   = full_pd;
        st_d.cnt_rst  = full_pd;
        st_d.cfg_err  = rule_err;
        st_d.pll_pd   = {N_PLL{full_pd}} | (susp_act ? cfg_pll_susp : '0);
        st_d.pll_hold = (susp_act && !full_pd) ? cfg_pll_susp : '0;
        for (int j = 0; j < N_OUT; j++) begin
            st_d.out_en[j] = !shdn_act
                           && !(susp_act && (cfg_out_susp[j] || dep_mask[j]))
                           && src_ready[j];
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_en   = st_q.out_en;
    assign pll_pd   = st_q.pll_pd;
    assign pll_hold = st_q.pll_hold;
    assign osc_pd   = st_q.osc_pd;
    assign cnt_rst  = st_q.cnt_rst;
    assign cfg_err  = st_q.cfg_err;

    // Cycles since reset, saturating; lets pin-history properties start clean.
    logic [1:0] settle_q;
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)              settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    // R2: three sampled lows on the pin leave every output released
    p_shdn_tristate_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (settle_q == 2'd3 && !oe_shdn_n && $past(!oe_shdn_n) && $past(!oe_shdn_n, 2))
        |=> (out_en == '0));

    // R3: oscillator power-down comes with full PLL power-down and silent outputs
    p_full_pd_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        osc_pd |-> (&pll_pd && cnt_rst && out_en == '0));

    // R5: a frozen PLL is always also powered down
    p_hold_implies_pd_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (pll_hold & ~pll_pd) == '0);

    // R8: full shutdown wins over suspend
    p_pd_priority_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        osc_pd |-> (pll_hold == '0));

    // R4: a driving output implies its PLL source is not powered down
    p_no_drive_from_pd_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(|(out_en & ~src_ready)) |-> 1'b0);

endmodule

// File: tb/pwr_susp_ctl_tb_top.sv
module pwr_susp_ctl_tb_top;

    localparam int N_PLL = 3;
    localparam int N_OUT = 6;
    localparam int LOCK_W = 8;
    localparam int SRC_W = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n;
    logic                   oe_shdn_n, susp_n;
    logic                   cfg_sys_shdn_en, cfg_susp_en;
    logic [N_PLL-1:0]       cfg_pll_susp;
    logic [N_OUT-1:0]       cfg_out_susp;
    logic [N_OUT*SRC_W-1:0] cfg_out_src;
    logic [LOCK_W-1:0]      cfg_lock_wait;
    logic [N_PLL-1:0]       pll_lock;
    logic [N_OUT-1:0]       out_en;
    logic [N_PLL-1:0]       pll_pd, pll_hold;
    logic                   osc_pd, cnt_rst, cfg_err;

    int total = 0;
    int bad = 0;

    pwr_susp_ctl #(.N_PLL(N_PLL), .N_OUT(N_OUT), .LOCK_W(LOCK_W)) dut_i (
        .clk_ref(clk), .rst_n(rst_n), .oe_shdn_n(oe_shdn_n), .susp_n(susp_n),
        .cfg_sys_shdn_en(cfg_sys_shdn_en), .cfg_susp_en(cfg_susp_en),
        .cfg_pll_susp(cfg_pll_susp), .cfg_out_susp(cfg_out_susp),
        .cfg_out_src(cfg_out_src), .cfg_lock_wait(cfg_lock_wait),
        .pll_lock(pll_lock), .out_en(out_en), .pll_pd(pll_pd),
        .pll_hold(pll_hold), .osc_pd(osc_pd), .cnt_rst(cnt_rst), .cfg_err(cfg_err));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1", "out_en", 32'(out_en), 0);
        chk("R1", "pll_pd", 32'(pll_pd), 0);
        chk("R1", "pll_hold", 32'(pll_hold), 0);
        chk("R1", "osc/cnt/err", {29'd0, osc_pd, cnt_rst, cfg_err}, 0);
        rst_n = 1'b1;
        step(5);
        // R4: reference outputs (3,5) drive without lock
        chk("R4", "ref-only after reset", 32'(out_en), 32'h28);
        pll_lock = 3'b111;
        step(3);
        chk("R4", "before lock qualified", 32'(out_en), 32'h28);
        step(5);
        chk("R4", "after lock qualified", 32'(out_en), 32'h3F);
    endtask

    // R2/R3: tri-state only, exact latency
    task automatic t_shdn_oe_only();
        cfg_sys_shdn_en = 1'b0;
        oe_shdn_n = 1'b0;
        step(2);
        chk("R2", "unchanged before third edge", 32'(out_en), 32'h3F);
        step(1);
        chk("R2", "released on third edge", 32'(out_en), 0);
        chk("R3", "no pll_pd when disabled", 32'(pll_pd), 0);
        chk("R3", "no osc_pd when disabled", {31'd0, osc_pd}, 0);
        oe_shdn_n = 1'b1;
        step(3);
        chk("R2", "outputs back after release", 32'(out_en), 32'h3F);
    endtask

    // R3/R4: full shutdown, relock with glitch
    task automatic t_full_shdn();
        cfg_sys_shdn_en = 1'b1;
        oe_shdn_n = 1'b0;
        step(3);
        chk("R3", "pll_pd full", 32'(pll_pd), 32'h7);
        chk("R3", "osc_pd and cnt_rst", {30'd0, osc_pd, cnt_rst}, 32'h3);
        chk("R2", "outputs off", 32'(out_en), 0);
        pll_lock = 3'b000;
        step(2);
        oe_shdn_n = 1'b1;
        step(3);
        chk("R3", "pll_pd released", 32'(pll_pd), 0);
        chk("R4", "only ref outputs", 32'(out_en), 32'h28);
        pll_lock[0] = 1'b1; step(2);
        pll_lock[0] = 1'b0; step(1);
        pll_lock[0] = 1'b1; step(4);
        chk("R4", "glitch restarts count", 32'(out_en), 32'h28);
        step(2);
        chk("R4", "pll0 outputs after full count", 32'(out_en), 32'h39);
        pll_lock = 3'b111;
        step(8);
        chk("R4", "all relocked", 32'(out_en), 32'h3F);
    endtask

    // R5: consistent suspend
    task automatic t_suspend();
        cfg_pll_susp = 3'b010;
        cfg_out_susp = 6'b001010;
        susp_n = 1'b0;
        step(3);
        chk("R5", "pll_pd masked", 32'(pll_pd), 32'h2);
        chk("R5", "pll_hold masked", 32'(pll_hold), 32'h2);
        chk("R5", "out_en masked", 32'(out_en), 32'h35);
        chk("R5", "osc stays up", {31'd0, osc_pd}, 0);
        chk("R7", "no rule error", {31'd0, cfg_err}, 0);
        susp_n = 1'b1;
        step(3);
        chk("R5", "pll_pd released", 32'(pll_pd), 0);
        chk("R4", "pll1 output waits relock", 32'(out_en), 32'h3D);
        step(8);
        chk("R4", "pll1 output back", 32'(out_en), 32'h3F);
    endtask

    // R7: broken rule flagged and forced
    task automatic t_cfg_err();
        cfg_pll_susp = 3'b001;
        cfg_out_susp = 6'b000001;
        step(2);
        chk("R7", "error flagged", {31'd0, cfg_err}, 1);
        chk("R7", "no effect without suspend", 32'(out_en), 32'h3F);
        susp_n = 1'b0;
        step(3);
        chk("R7", "dependent output forced off", 32'(out_en), 32'h2E);
        susp_n = 1'b1;
        cfg_out_susp = 6'b010001;
        step(2);
        chk("R7", "error clears", {31'd0, cfg_err}, 0);
        step(10);
        chk("R7", "recovered", 32'(out_en), 32'h3F);
    endtask

    // R8: shutdown beats suspend
    task automatic t_priority();
        cfg_pll_susp = 3'b100;
        cfg_out_susp = 6'b000100;
        cfg_sys_shdn_en = 1'b1;
        oe_shdn_n = 1'b0;
        susp_n = 1'b0;
        step(3);
        chk("R8", "no hold during shutdown", 32'(pll_hold), 0);
        chk("R8", "all pll_pd", 32'(pll_pd), 32'h7);
        chk("R8", "outputs off", 32'(out_en), 0);
        oe_shdn_n = 1'b1;
        step(3);
        chk("R5", "suspend takes over pll_pd", 32'(pll_pd), 32'h4);
        chk("R5", "suspend takes over hold", 32'(pll_hold), 32'h4);
        chk("R4", "ref outputs only", 32'(out_en), 32'h28);
        step(8);
        chk("R5", "unsuspended relocked", 32'(out_en), 32'h3B);
        susp_n = 1'b1;
        step(12);
        chk("R5", "all back", 32'(out_en), 32'h3F);
    endtask

    // R6: suspend function off
    task automatic t_susp_disabled();
        cfg_susp_en = 1'b0;
        cfg_pll_susp = 3'b111;
        cfg_out_susp = 6'b111111;
        susp_n = 1'b0;
        step(6);
        chk("R6", "outputs unaffected", 32'(out_en), 32'h3F);
        chk("R6", "pll_pd unaffected", 32'(pll_pd), 0);
        chk("R6", "pll_hold unaffected", 32'(pll_hold), 0);
        susp_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        oe_shdn_n = 1'b1;
        susp_n = 1'b1;
        cfg_sys_shdn_en = 1'b1;
        cfg_susp_en = 1'b1;
        cfg_pll_susp = '0;
        cfg_out_susp = '0;
        // out0:PLL0 out1:PLL1 out2:PLL2 out3:ref out4:PLL0 out5:ref
        cfg_out_src = {2'd0, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1};
        cfg_lock_wait = 8'd4;
        pll_lock = '0;
        t_reset();
        t_shdn_oe_only();
        t_full_shdn();
        t_suspend();
        t_cfg_err();
        t_priority();
        t_susp_disabled();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule